// File: doc/BRIEF.md
# Physical Frame Width Control for TLB Entry Registers

This block holds three MMU registers: one 32-bit page-control register and two 64-bit TLB entry-low registers. Software writes them through a single register-write port that carries a select, write data, a strobe and a flag. The flag tells a 32-bit move apart from a 64-bit doubleword move. The control register holds two enables for the read-inhibit and execute-inhibit bits and one enable for large physical addresses. A static capability input says whether the core supports large physical addresses at all.

From the capability input and the large-address enable, the block derives a physical-address mask. It is all ones over `PA_MAX_BITS` bits when large addressing is active, and over `PA_NARROW_BITS` bits when it is not. Every write to an entry register keeps only the frame bits that this mask, shifted right by six, allows. A 32-bit move keeps at most the low 30 bits. The two inhibit bits are stored at the top of the register, and only when their enables are set. The TLB lookup itself sits outside the block.

Top module: `lpa_entrylo_ctrl`

## Requirements
- R1: Reset is synchronous and active high. It clears the control register and both entry registers to zero, and it sets the derived mask to the narrow width, all ones over `PA_NARROW_BITS` bits (0x0000_0000_FFFF_FFFF by default).
- R2: A write with select 0 updates only the control bits set in `CTRL_WMASK` (default 0xE000_0000, which is bits 31..29). Every other control bit keeps its value, which is zero.
- R3: Large addressing is active only when `cap_lpa_i` is 1 and control bit 29 is 1. While it is active the mask is all ones over `PA_MAX_BITS` bits (0xFF_FFFF_FFFF by default); otherwise the mask is narrow. Setting bit 29 without the capability has no effect.
- R4: A control write changes the mask at the same clock edge as the register itself. An entry write in the very next cycle therefore uses the new width.
- R5: A doubleword entry write stores the write data ANDed with the mask shifted right by 6 in register bits 61:0.
- R6: A 32-bit entry write also limits the kept bits to positions 29:0, so register bits 61:30 become zero.
- R7: The read-inhibit bit (register bit 63) is stored only if control bit 31 is 1. The execute-inhibit bit (register bit 62) is stored only if control bit 30 is 1. If its enable is 0, the bit is stored as 0.
- R8: In a 32-bit move the two inhibit bits come from data bits 31 (read) and 30 (execute). In a doubleword move they come from data bits 63 and 62. In both cases they land at register bits 63:62.
- R9: Select 1 writes entry register 0 and select 2 writes entry register 1. A write with select 3 changes no register, and a write to one register leaves the other two unchanged.
- R10: The read ports show the stored values unchanged, and the registers hold their values while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_lpa_i | input | 1 | Static capability: large physical addresses supported |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 control, 1 entry 0, 2 entry 1, 3 none |
| wr_dword_i | input | 1 | 1 for a 64-bit move, 0 for a 32-bit move |
| wr_data_i | input | 64 | Write data |
| ctrl_q_o | output | 32 | Control register read port |
| entry0_q_o | output | 64 | Entry register 0 read port |
| entry1_q_o | output | 64 | Entry register 1 read port |
| pa_mask_o | output | 64 | Derived physical-address mask |

## Verification
The bench builds the block with its default parameters: a 40-bit maximum width, a 32-bit narrow width and writable control bits 31..29. These values make the 34-bit and 26-bit frame limits for doubleword moves visible, and they show how the 30-bit cap on 32-bit moves falls below one limit and above the other. The bench resets the block once with the capability input low and once with it high. This shows that the enable alone never widens the mask, and it checks widening and narrowing back-to-back with entry writes.

// File: rtl/lpa_pkg.sv
package lpa_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_ENT0  = 2'd1,
    SEL_ENT1  = 2'd2,
    SEL_NONE  = 2'd3
  } lpa_sel_e;

  localparam int RD_INH_EN_BIT = 31;
  localparam int EX_INH_EN_BIT = 30;
  localparam int LPA_EN_BIT    = 29;
  localparam int FRAME_SHIFT   = 6;
  localparam int WORD_KEEP     = 30;

  function automatic logic [63:0] ones_mask(input int unsigned nbits);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) m[i] = (i < nbits);
    return m;
  endfunction

endpackage

// File: rtl/lpa_ctrl_reg.sv
module lpa_ctrl_reg #(
  parameter int          CTRL_W = 32,
  parameter logic [31:0] WMASK  = 32'hE000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_next,
  output logic [CTRL_W-1:0] ctrl_q
);
  localparam logic [CTRL_W-1:0] WM = WMASK[CTRL_W-1:0];

  always_comb begin
    ctrl_next = ctrl_q;
    if (we) ctrl_next = (wdata & WM) | (ctrl_q & ~WM);
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_next;
  end

  // R2: bits outside the writable set never leave their reset value
  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q & ~WM) == '0);

  // R10: no strobe, no change
  a_r10_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(ctrl_q));

endmodule

// File: rtl/lpa_mask_gen.sv
module lpa_mask_gen
  import lpa_pkg::*;
#(
  parameter int PA_MAX_BITS    = 40,
  parameter int PA_NARROW_BITS = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cap,
  input  logic        lpa_en_next,
  output logic [63:0] mask_q
);
  localparam logic [63:0] WIDE   = ones_mask(PA_MAX_BITS);
  localparam logic [63:0] NARROW = ones_mask(PA_NARROW_BITS);

  logic wide_mode;
  assign wide_mode = cap & lpa_en_next;

  always_ff @(posedge clk) begin
    if (rst)            mask_q <= NARROW;
    else if (wide_mode) mask_q <= WIDE;
    else                mask_q <= NARROW;
  end

  // R3: the mask is always one of the two legal widths
  a_r3_legal_width: assert property (@(posedge clk) disable iff (rst)
    (mask_q == WIDE) || (mask_q == NARROW));

endmodule

// File: rtl/lpa_entry_reg.sv
module lpa_entry_reg
  import lpa_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic        dword,
  input  logic [63:0] wdata,
  input  logic [63:0] frame_keep,
  input  logic        rd_inh_en,
  input  logic        ex_inh_en,
  output logic [63:0] q
);
  localparam logic [63:0] WORD_LIMIT = ones_mask(WORD_KEEP);
  localparam logic [63:0] LOW62      = ones_mask(62);

  logic [63:0] keep;
  logic        rd_inh, ex_inh;
  logic [63:0] next_val;

  always_comb begin
    keep   = (dword ? frame_keep : (frame_keep & WORD_LIMIT)) & LOW62;
    rd_inh = (dword ? wdata[63] : wdata[31]) & rd_inh_en;
    ex_inh = (dword ? wdata[62] : wdata[30]) & ex_inh_en;
    next_val = (wdata & keep) | {rd_inh, ex_inh, 62'd0};
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= next_val;
  end

  // R6: a 32-bit move leaves the middle bits zero
  a_r6_word_mid_zero: assert property (@(posedge clk) disable iff (rst)
    we && !dword |=> q[61:30] == '0);

  // R7: disabled inhibit bits are stored as zero
  a_r7_rd_inh_gated: assert property (@(posedge clk) disable iff (rst)
    we && !rd_inh_en |=> !q[63]);
  a_r7_ex_inh_gated: assert property (@(posedge clk) disable iff (rst)
    we && !ex_inh_en |=> !q[62]);

  // R10: register holds without a strobe
  a_r10_entry_hold: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));

endmodule

// File: rtl/lpa_entrylo_ctrl.sv
module lpa_entrylo_ctrl
  import lpa_pkg::*;
#(
  parameter int          PA_MAX_BITS    = 40,
  parameter int          PA_NARROW_BITS = 32,
  parameter logic [31:0] CTRL_WMASK     = 32'hE000_0000,
  parameter int          N_ENTRY        = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cap_lpa_i,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_sel_i,
  input  logic        wr_dword_i,
  input  logic [63:0] wr_data_i,
  output logic [31:0] ctrl_q_o,
  output logic [63:0] entry0_q_o,
  output logic [63:0] entry1_q_o,
  output logic [63:0] pa_mask_o
);
  localparam logic [63:0] WIDE   = ones_mask(PA_MAX_BITS);
  localparam logic [63:0] NARROW = ones_mask(PA_NARROW_BITS);

  logic [31:0] ctrl_next, ctrl_q;
  logic [63:0] mask_q;
  logic [63:0] frame_keep;
  logic [63:0] ent_q [N_ENTRY];

  lpa_ctrl_reg #(.CTRL_W(32), .WMASK(CTRL_WMASK)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .we        (wr_en_i && (wr_sel_i == SEL_CTRL)),
    .wdata     (wr_data_i[31:0]),
    .ctrl_next (ctrl_next),
    .ctrl_q    (ctrl_q)
  );

  lpa_mask_gen #(.PA_MAX_BITS(PA_MAX_BITS), .PA_NARROW_BITS(PA_NARROW_BITS)) u_mask (
    .clk         (clk),
    .rst         (rst),
    .cap         (cap_lpa_i),
    .lpa_en_next (ctrl_next[LPA_EN_BIT]),
    .mask_q      (mask_q)
  );

  assign frame_keep = mask_q >> FRAME_SHIFT;

  for (genvar g = 0; g < N_ENTRY; g++) begin : g_entry
    lpa_entry_reg u_ent (
      .clk        (clk),
      .rst        (rst),
      .we         (wr_en_i && (wr_sel_i == 2'(g + 1))),
      .dword      (wr_dword_i),
      .wdata      (wr_data_i),
      .frame_keep (frame_keep),
      .rd_inh_en  (ctrl_q[RD_INH_EN_BIT]),
      .ex_inh_en  (ctrl_q[EX_INH_EN_BIT]),
      .q          (ent_q[g])
    );
  end

  assign ctrl_q_o   = ctrl_q;
  assign entry0_q_o = ent_q[0];
  assign entry1_q_o = ent_q[1];
  assign pa_mask_o  = mask_q;

  // R3: mask width tracks capability AND stored enable
  a_r3_mode_width: assert property (@(posedge clk) disable iff (rst)
    pa_mask_o == ((cap_lpa_i && ctrl_q[LPA_EN_BIT]) ? WIDE : NARROW));

  // R9: the unused select touches nothing
  a_r9_none_ignored: assert property (@(posedge clk) disable iff (rst)
    wr_en_i && (wr_sel_i == SEL_NONE) |=>
      $stable(ctrl_q) && $stable(ent_q[0]) && $stable(ent_q[1]));

endmodule

// File: tb/lpa_entrylo_ctrl_tb.sv
module lpa_entrylo_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic        wr_dword = 1'b0;
  logic [63:0] wr_data = '0;
  logic [31:0] ctrl_q;
  logic [63:0] e0_q, e1_q, mask_q;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  localparam logic [63:0] ALL1      = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] M_NARROW  = 64'h0000_0000_FFFF_FFFF;
  localparam logic [63:0] M_WIDE    = 64'h0000_00FF_FFFF_FFFF;
  localparam logic [63:0] K_NARROW  = 64'h0000_0000_03FF_FFFF;
  localparam logic [63:0] K_WIDE    = 64'h0000_0003_FFFF_FFFF;
  localparam logic [63:0] K_WORD    = 64'h0000_0000_3FFF_FFFF;
  localparam logic [63:0] INH_BOTH  = 64'hC000_0000_0000_0000;

  always #2 clk = ~clk;

  lpa_entrylo_ctrl u_dut (
    .clk        (clk),
    .rst        (rst),
    .cap_lpa_i  (cap),
    .wr_en_i    (wr_en),
    .wr_sel_i   (wr_sel),
    .wr_dword_i (wr_dword),
    .wr_data_i  (wr_data),
    .ctrl_q_o   (ctrl_q),
    .entry0_q_o (e0_q),
    .entry1_q_o (e1_q),
    .pa_mask_o  (mask_q)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic cap_val);
    @(negedge clk);
    rst = 1'b1; cap = cap_val; wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic dw, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_dword = dw; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset(1'b0);
    check("R1 ctrl", {32'd0, ctrl_q}, 64'd0);
    check("R1 entry0", e0_q, 64'd0);
    check("R1 entry1", e1_q, 64'd0);
    check("R1 mask", mask_q, M_NARROW);
  endtask

  task automatic t_no_capability();
    wr(2'd0, 1'b0, ALL1);
    check("R2 writable bits only", {32'd0, ctrl_q}, 64'hE000_0000);
    check("R3 enable without capability", mask_q, M_NARROW);
    wr(2'd1, 1'b1, ALL1);
    check("R5 narrow dword frame", e0_q, INH_BOTH | K_NARROW);
    check("R9 entry1 untouched", e1_q, 64'd0);
  endtask

  task automatic t_wide_mode();
    do_reset(1'b1);
    check("R1 mask after reset", mask_q, M_NARROW);
    // control write followed at once by an entry write
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_dword = 1'b0; wr_data = 64'h0000_0000_E000_0000;
    @(negedge clk);
    check("R3 wide mask", mask_q, M_WIDE);
    wr_sel = 2'd2; wr_dword = 1'b1; wr_data = ALL1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R4 next-cycle write uses wide frame", e1_q, INH_BOTH | K_WIDE);
    wr(2'd1, 1'b0, ALL1);
    check("R6 word move capped at 30 bits", e0_q, INH_BOTH | K_WORD);
    wr(2'd1, 1'b0, 64'h4000_0000_8000_0005);
    check("R8 word move inhibit source", e0_q, 64'h8000_0000_0000_0005);
    wr(2'd1, 1'b1, 64'h4000_0000_8000_0005);
    check("R8 dword move inhibit source", e0_q, 64'h4000_0000_8000_0005);
    check("R9 entry1 unchanged", e1_q, INH_BOTH | K_WIDE);
  endtask

  task automatic t_inhibit_disabled();
    wr(2'd0, 1'b0, 64'h0000_0000_2000_0000);
    check("R2 clear inhibit enables", {32'd0, ctrl_q}, 64'h2000_0000);
    wr(2'd1, 1'b1, ALL1);
    check("R7 inhibits dropped dword", e0_q, K_WIDE);
    wr(2'd2, 1'b0, ALL1);
    check("R7 inhibits dropped word", e1_q, K_WORD);
    wr(2'd0, 1'b0, 64'h0000_0000_4000_0000);
    wr(2'd2, 1'b0, ALL1);
    check("R7 only execute-inhibit kept", e1_q, 64'h4000_0000_0000_0000 | K_NARROW);
  endtask

  task automatic t_narrow_again();
    wr(2'd0, 1'b0, 64'h0000_0000_1FFF_FFFF);
    check("R2 read-only bits stay zero", {32'd0, ctrl_q}, 64'd0);
    check("R3 mask narrows", mask_q, M_NARROW);
    wr(2'd1, 1'b1, ALL1);
    check("R4 narrow frame after disable", e0_q, K_NARROW);
  endtask

  task automatic t_ignored_select();
    wr(2'd0, 1'b0, 64'h0000_0000_E000_0000);
    wr(2'd3, 1'b1, 64'h1234_5678_9ABC_DEF0);
    check("R9 sel3 ctrl", {32'd0, ctrl_q}, 64'hE000_0000);
    check("R9 sel3 entry0", e0_q, K_NARROW);
    check("R9 sel3 entry1", e1_q, 64'h4000_0000_0000_0000 | K_NARROW);
    wr_data = ALL1;
    repeat (3) @(negedge clk);
    check("R10 idle hold entry0", e0_q, K_NARROW);
    check("R10 idle hold mask", mask_q, M_WIDE);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_no_capability();
    t_wide_mode();
    t_inhibit_disabled();
    t_narrow_again();
    t_ignored_select();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule